// File: doc/BRIEF.md
# Control-Flow Signature Watchdog with Spare-Processor Switchover

This block runs beside a small control processor and checks its control flow without slowing it down. Each unit of work the processor performs is framed as a phase. A start strobe carries the phase number and an end strobe closes the phase. Between the two strobes, every valid address the processor issues is folded into a 16-bit multiple-input signature register. When the end strobe arrives, the folded value is compared against a reference signature for that phase. The reference comes from a small table that is loaded before operation.

A mismatch raises an error flag. It also briefly drops the operation-request line, which tells the processor to run the whole phase again. Repeated failures of the same phase escalate. On the third consecutive failure, the block moves a bypass select from the active processor to a cold spare. It holds the spare in reset for a fixed number of cycles, then raises the request line so that the failed phase starts over on the new processor. Only one processor is connected at any time.

Top module: `flow_sig_guard`

## Requirements
- R1: After reset, err_flag is 0, op_go is 1, cpu_sel is 0 (primary processor connected) and cpu_rst is 0.
- R2: The signature starts at 16'hFFFF on an accepted ph_start. On each cycle where a phase is open, addr_valid is 1 and neither strobe is high, the signature becomes the left shift of the current value, XOR 16'h1021 when the old bit 15 was 1, XOR the zero-extended address. Cycles with addr_valid at 0 leave the signature unchanged, whatever value is on addr.
- R3: A write with tbl_we at 1 stores tbl_data as the reference for phase tbl_idx, and a later write to the same index replaces it. The reference used by a phase is read when its ph_start is accepted.
- R4: On an accepted ph_end, err_flag is 1 for exactly the next cycle if the signature differs from the reference, and stays 0 if it matches.
- R5: A failure that is not the third in a row drops op_go to 0 for exactly one cycle, starting one cycle after the ph_end edge.
- R6: The third consecutive failure of the same phase, while the primary processor is connected, sets cpu_sel to 1 and raises cpu_rst for HOLD_CYC cycles. op_go is 0 during those cycles and returns to 1 when cpu_rst falls.
- R7: A passing phase clears the failure count. A failure of a phase number different from the one that failed last restarts the count at one.
- R8: cpu_sel never returns to 0. When the spare is connected, a third consecutive failure only causes a one-cycle retry: cpu_rst stays 0.
- R9: A ph_end with no open phase is ignored. Both strobes are ignored while cpu_rst is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Reference-table write enable |
| tbl_idx | input | PH_W | Phase number to write |
| tbl_data | input | 16 | Reference signature to store |
| ph_start | input | 1 | Phase-start strobe |
| ph_id | input | PH_W | Phase number, sampled with ph_start |
| ph_end | input | 1 | Phase-end strobe |
| addr_valid | input | 1 | Processor address is valid this cycle |
| addr | input | ADDR_W | Processor address bus |
| err_flag | output | 1 | One-cycle signature-mismatch flag |
| op_go | output | 1 | Operation-request line; low forces a phase repeat |
| cpu_sel | output | 1 | Bypass select: 0 primary, 1 spare |
| cpu_rst | output | 1 | Reset hold for the swapped-in processor |

## Verification
All outputs are registered. err_flag and the first low cycle of op_go therefore appear in the cycle right after the clock edge that samples ph_end. On a switchover, cpu_rst stays high for HOLD_CYC cycles counted from that same edge. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each result is taken exactly one register stage after its cause. The bench also counts falling edges to measure the single-cycle retry pulse and the length of the reset hold.

// File: rtl/flow_guard_pkg.sv
package flow_guard_pkg;
  parameter int unsigned SIG_W = 16;
  typedef logic [SIG_W-1:0] sig_t;

  // one clock of the multiple-input signature register
  function automatic sig_t misr_step(sig_t s, sig_t d, sig_t poly);
    sig_t nxt;
    nxt = {s[SIG_W-2:0], 1'b0};
    if (s[SIG_W-1]) nxt = nxt ^ poly;
    return nxt ^ d;
  endfunction
endpackage

// File: rtl/fsg_misr.sv
module fsg_misr
  import flow_guard_pkg::*;
#(
  parameter sig_t POLY = 16'h1021,
  parameter sig_t SEED = 16'hFFFF
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic fold,
  input  sig_t din,
  output sig_t sig
);
  always_ff @(posedge clk) begin
    if (rst)        sig <= SEED;
    else if (clear) sig <= SEED;
    else if (fold)  sig <= misr_step(sig, din, POLY);
  end

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!clear && !fold) |=> $stable(sig));
  p_seed_on_clear_r2: assert property (@(posedge clk) disable iff (rst)
    clear |=> (sig == SEED));
endmodule

// File: rtl/fsg_exp_table.sv
module fsg_exp_table
  import flow_guard_pkg::*;
#(
  parameter int unsigned PH_W = 3,
  localparam int unsigned DEPTH = 1 << PH_W
) (
  input  logic            clk,
  input  logic            we,
  input  logic [PH_W-1:0] wa,
  input  sig_t            wd,
  input  logic            re,
  input  logic [PH_W-1:0] ra,
  output sig_t            rd
);
  sig_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rd <= mem[ra];
  end
endmodule

// File: rtl/fsg_recovery.sv
module fsg_recovery #(
  parameter int unsigned PH_W     = 3,
  parameter int unsigned MAX_FAIL = 3,
  parameter int unsigned HOLD_CYC = 8,
  localparam int unsigned CW = $clog2(MAX_FAIL + 1),
  localparam int unsigned HW = $clog2(HOLD_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            chk_valid,
  input  logic            chk_fail,
  input  logic [PH_W-1:0] chk_ph,
  output logic            err_flag,
  output logic            op_go,
  output logic            cpu_sel,
  output logic            cpu_rst
);
  logic [CW-1:0]   fail_cnt, next_cnt;
  logic [PH_W-1:0] last_ph;
  logic [HW-1:0]   hold_cnt;

  always_comb begin
    if (fail_cnt != '0 && chk_ph == last_ph) next_cnt = fail_cnt + CW'(1);
    else                                     next_cnt = CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      op_go    <= 1'b1;
      cpu_sel  <= 1'b0;
      cpu_rst  <= 1'b0;
      fail_cnt <= '0;
      last_ph  <= '0;
      hold_cnt <= '0;
    end else begin
      err_flag <= chk_valid & chk_fail;
      if (cpu_rst) begin
        hold_cnt <= hold_cnt - HW'(1);
        if (hold_cnt == HW'(1)) begin
          cpu_rst <= 1'b0;
          op_go   <= 1'b1;
        end
      end else if (chk_valid && chk_fail) begin
        last_ph <= chk_ph;
        op_go   <= 1'b0;
        if (next_cnt == CW'(MAX_FAIL)) begin
          fail_cnt <= '0;
          if (!cpu_sel) begin
            cpu_sel  <= 1'b1;
            cpu_rst  <= 1'b1;
            hold_cnt <= HW'(HOLD_CYC);
          end
        end else begin
          fail_cnt <= next_cnt;
        end
      end else begin
        op_go <= 1'b1;
        if (chk_valid) fail_cnt <= '0;
      end
    end
  end

  p_retry_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(op_go) && !cpu_rst) |=> op_go);
  p_sel_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_sel |=> cpu_sel);
  p_rst_only_spare_r6: assert property (@(posedge clk) disable iff (rst)
    cpu_rst |-> (cpu_sel && !op_go));
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
    fail_cnt < CW'(MAX_FAIL));
  p_err_single_r4: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> !err_flag);
endmodule

// File: rtl/flow_sig_guard.sv
module flow_sig_guard
  import flow_guard_pkg::*;
#(
  parameter int unsigned PH_W     = 3,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned MAX_FAIL = 3,
  parameter int unsigned HOLD_CYC = 8,
  parameter sig_t        POLY     = 16'h1021,
  parameter sig_t        SEED     = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [PH_W-1:0]   tbl_idx,
  input  logic [SIG_W-1:0]  tbl_data,
  input  logic              ph_start,
  input  logic [PH_W-1:0]   ph_id,
  input  logic              ph_end,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              err_flag,
  output logic              op_go,
  output logic              cpu_sel,
  output logic              cpu_rst
);
  logic            active;
  logic [PH_W-1:0] ph_q;
  logic            start_ok, end_ok, fold;
  sig_t            sig, exp_q, din;

  assign start_ok = ph_start & ~cpu_rst;
  assign end_ok   = ph_end & active & ~ph_start & ~cpu_rst;
  assign fold     = active & addr_valid & ~ph_start & ~ph_end;
  assign din      = sig_t'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      ph_q   <= '0;
    end else if (cpu_rst) begin
      active <= 1'b0;
    end else if (start_ok) begin
      active <= 1'b1;
      ph_q   <= ph_id;
    end else if (end_ok) begin
      active <= 1'b0;
    end
  end

  fsg_misr #(.POLY(POLY), .SEED(SEED)) u_misr (
    .clk(clk), .rst(rst), .clear(start_ok), .fold(fold), .din(din), .sig(sig)
  );

  fsg_exp_table #(.PH_W(PH_W)) u_tbl (
    .clk(clk), .we(tbl_we), .wa(tbl_idx), .wd(tbl_data),
    .re(start_ok), .ra(ph_id), .rd(exp_q)
  );

  fsg_recovery #(.PH_W(PH_W), .MAX_FAIL(MAX_FAIL), .HOLD_CYC(HOLD_CYC)) u_rec (
    .clk(clk), .rst(rst), .chk_valid(end_ok), .chk_fail(sig != exp_q),
    .chk_ph(ph_q), .err_flag(err_flag), .op_go(op_go),
    .cpu_sel(cpu_sel), .cpu_rst(cpu_rst)
  );

  p_err_needs_end_r9: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> ($past(ph_end) && $past(active)));
  p_err_drops_go_r5: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> !op_go);
endmodule

// File: tb/tb_flow_sig_guard.sv
module tb_flow_sig_guard;
  localparam int CLK_NS = 10;
  localparam int HOLD = 8;

  logic clk = 0, rst = 1;
  logic tbl_we = 0; logic [2:0] tbl_idx = 0; logic [15:0] tbl_data = 0;
  logic ph_start = 0; logic [2:0] ph_id = 0; logic ph_end = 0;
  logic addr_valid = 0; logic [15:0] addr = 0;
  logic err_flag, op_go, cpu_sel, cpu_rst;

  int total = 0, bad = 0;
  logic [15:0] seq [8][16];
  int len [8];
  int m_cnt = 0, m_last = 0; bit m_sel = 0;

  always #(CLK_NS/2) clk = ~clk;

  flow_sig_guard #(.HOLD_CYC(HOLD)) dut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
    .ph_start(ph_start), .ph_id(ph_id), .ph_end(ph_end),
    .addr_valid(addr_valid), .addr(addr),
    .err_flag(err_flag), .op_go(op_go), .cpu_sel(cpu_sel), .cpu_rst(cpu_rst)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_sig(int id, int bad_pos);
    logic [15:0] s = 16'hFFFF;
    for (int k = 0; k < len[id]; k++) begin
      logic [15:0] d = seq[id][k];
      logic fb = s[15];
      if (k == bad_pos) d = d ^ 16'h0100;
      s = {s[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000) ^ d;
    end
    return s;
  endfunction

  task automatic write_tbl(int id, logic [15:0] v);
    @(negedge clk); tbl_we = 1; tbl_idx = 3'(id); tbl_data = v;
    @(negedge clk); tbl_we = 0;
  endtask

  // runs one phase; corrupt flips a bit of one address
  task automatic run_phase(int id, bit corrupt);
    int pos = corrupt ? $urandom_range(0, len[id]-1) : -1;
    bit exp_fail, esc;
    int hc;
    @(negedge clk); ph_start = 1; ph_id = 3'(id);
    @(negedge clk); ph_start = 0;
    for (int k = 0; k < len[id]; k++) begin
      if ($urandom_range(0, 3) == 0) begin
        addr_valid = 0; addr = 16'($urandom); @(negedge clk);  // R2 idle noise
      end
      addr_valid = 1; addr = (k == pos) ? seq[id][k] ^ 16'h0100 : seq[id][k];
      @(negedge clk);
    end
    addr_valid = 0; addr = 16'($urandom); ph_end = 1;
    @(negedge clk); ph_end = 0;
    // bench model of recovery
    exp_fail = (ref_sig(id, pos) != ref_sig(id, -1));
    esc = 0;
    if (exp_fail) begin
      m_cnt = (m_cnt != 0 && m_last == id) ? m_cnt + 1 : 1;
      m_last = id;
      if (m_cnt == 3) begin m_cnt = 0; if (!m_sel) begin m_sel = 1; esc = 1; end end
    end else m_cnt = 0;
    check("R4 err_flag", err_flag, exp_fail);
    check("R5 op_go after end", op_go, !exp_fail);
    check("R8 cpu_sel", cpu_sel, m_sel);
    check("R6 cpu_rst", cpu_rst, esc);
    if (esc) begin
      hc = 1;
      while (cpu_rst && hc < 100) begin
        if (hc == 2) begin ph_end = 1; ph_start = 1; end   // R9 ignored during hold
        @(negedge clk); ph_end = 0; ph_start = 0;
        check("R9 no err in hold", err_flag, 0);
        if (cpu_rst) begin hc++; check("R6 op_go low in hold", op_go, 0); end
      end
      check("R6 hold length", hc, HOLD);
      check("R6 op_go after hold", op_go, 1);
    end else begin
      @(negedge clk);
      check("R5 op_go restored", op_go, 1);
      check("R4 err_flag single", err_flag, 0);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 err_flag", err_flag, 0);
    check("R1 op_go", op_go, 1);
    check("R1 cpu_sel", cpu_sel, 0);
    check("R1 cpu_rst", cpu_rst, 0);
    for (int i = 0; i < 8; i++) begin
      len[i] = $urandom_range(1, 16);
      for (int k = 0; k < 16; k++) seq[i][k] = 16'($urandom);
      write_tbl(i, 16'h0BAD);                 // R3 overwritten below
      write_tbl(i, ref_sig(i, -1));
    end
    // R9: end strobe with no open phase
    @(negedge clk); ph_end = 1; @(negedge clk); ph_end = 0;
    check("R9 stray end err", err_flag, 0);
    check("R9 stray end go", op_go, 1);
    // random mix of passes; R2 R3 R4
    for (int n = 0; n < 20; n++) run_phase($urandom_range(0, 7), 0);
    // R7: fail, fail, pass, fail, fail -> no switch
    run_phase(1, 1); run_phase(1, 1); run_phase(1, 0);
    run_phase(1, 1); run_phase(1, 1);
    check("R7 no switch after pass", cpu_sel, 0);
    // R7: different phase restarts count
    run_phase(2, 1);
    check("R7 no switch other phase", cpu_sel, 0);
    run_phase(2, 1);
    // third in a row on primary -> R6 switch
    run_phase(2, 1);
    check("R6 switched", cpu_sel, 1);
    run_phase(2, 0);
    // R8: three failures on spare only retry
    run_phase(4, 1); run_phase(4, 1); run_phase(4, 1);
    check("R8 sel kept", cpu_sel, 1);
    check("R8 no reset", cpu_rst, 0);
    for (int n = 0; n < 30; n++) run_phase($urandom_range(0, 7), $urandom_range(0, 2) == 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule